// File: doc/BRIEF.md
# External Interrupt Request Controller

This block collects eight external interrupt request pins. Each pin goes through a two-stage synchronizer. A per-pin sense setting then picks the trigger condition: low level, falling edge, rising edge or either edge. A detected condition sets a sticky pending flag. Software clears that flag by writing a one to it, except that a pin in low-level mode that is still low sets its flag again at once.

Pending flags are gated by per-pin enable bits. Each enabled pending pin competes for the CPU with a programmable priority level. The highest level wins. Among equal levels, the pin with the lower index wins, so pin 0 carries the lowest vector number and the highest fixed rank.

The winner's level is compared with the CPU mask level input. The block raises its request output only when the winner's level is strictly above the mask. The 5-bit vector number of the winning pin is presented together with that request. Configuration uses a small word-wide register port with combinational read-back.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset the flag, enable, sense and level registers read as zero, and `irq_o` and `vec_o` are 0.
- R2: Each pin's sense field is encoded as 00 = low level, 01 = falling edge, 10 = rising edge, 11 = either edge. Detection uses samples taken after a two-flop synchronizer. A pin change driven before clock edge k shows in its flag after edge k+2.
- R3: A set flag stays set until a write to address 0 has a one in that pin's bit position. Zero bits in that write leave their flags unchanged.
- R4: A pin requests the CPU only when both its flag and its enable bit (address 1, bit n) are 1. Flags set whether or not the pin is enabled.
- R5: For pin n, the vector number is 16 + n (pin 0 is 16, pin 7 is 23). While `irq_o` is 0, `vec_o` is 0.
- R6: Among requesting pins, the highest priority level wins. On equal levels, the lower pin index (the lower vector) wins.
- R7: `irq_o` is 1 only when the winner's level is strictly greater than `mask_i`. `irq_o` and `vec_o` are registered and update one clock after their inputs change.
- R8: In low-level mode, a clear has no effect while the synchronized pin is still low. The flag stays set.
- R9: The register map is as follows. Address 0 holds the flags (bit n) and is write-one-to-clear. Address 1 holds the enables (bit n). Address 2 holds the sense fields, bits [2n+1:2n]. Address 3 holds the levels, bits [3n+2:3n]. Reads return the current values, with unused bits at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | External request pins, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 24 | Register write data |
| rdata_o | output | 24 | Register read data for `addr_i` (combinational) |
| mask_i | input | 3 | CPU interrupt mask level |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 5 | Vector number of the winning pin |

## Verification
The mask property compares the registered request with the mask from the previous cycle. It therefore takes for granted only that `mask_i` is a clean synchronous level. It makes no assumption about how long the mask is held. The flag properties assume that a clear reaches a flag only through a write to address 0, and that the pins may toggle at any time, because they are synchronized inside the block. The stimulus drives the pins and the register port on falling clock edges. It holds each pin level for at least four cycles, so the bench samples flags only after the three-register path has settled.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        REG_FLAG   = 2'd0,
        REG_ENABLE = 2'd1,
        REG_SENSE  = 2'd2,
        REG_LEVEL  = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
    parameter int unsigned N_PINS = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_PINS-1:0] pin_i,
    output logic [N_PINS-1:0] cur_o,
    output logic [N_PINS-1:0] prev_o
);
    typedef struct packed {
        logic [N_PINS-1:0] meta;
        logic [N_PINS-1:0] cur;
        logic [N_PINS-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.meta = pin_i;
        st_d.cur  = st_q.meta;
        st_d.prev = st_q.cur;
    end

    // Idle-high reset: no spurious level or edge hit after reset
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '1;
        else         st_q <= st_d;
    end

    assign cur_o  = st_q.cur;
    assign prev_o = st_q.prev;
endmodule

// File: rtl/extirq_detect.sv
module extirq_detect
    import extirq_pkg::*;
#(
    parameter int unsigned N_PINS = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [N_PINS-1:0]   cur_i,
    input  logic [N_PINS-1:0]   prev_i,
    input  logic [2*N_PINS-1:0] sense_i,
    input  logic [N_PINS-1:0]   clr_i,
    output logic [N_PINS-1:0]   flag_o
);
    typedef struct packed {
        logic [N_PINS-1:0] flag;
    } det_t;

    det_t              st_d, st_q;
    logic [N_PINS-1:0] hit;

    always_comb begin
        for (int i = 0; i < N_PINS; i++) begin
            unique case (sense_e'(sense_i[2*i +: 2]))
                SENSE_LOW:  hit[i] = !cur_i[i];
                SENSE_FALL: hit[i] = prev_i[i] && !cur_i[i];
                SENSE_RISE: hit[i] = !prev_i[i] && cur_i[i];
                default:    hit[i] = prev_i[i] ^ cur_i[i];
            endcase
        end
        // A new hit dominates a clear in the same cycle
        st_d.flag = hit | (st_q.flag & ~clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/extirq_arb.sv
module extirq_arb #(
    parameter int unsigned N_PINS   = 8,
    parameter int unsigned LVL_W    = 3,
    parameter int unsigned VEC_W    = 5,
    parameter int unsigned VEC_BASE = 16
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [N_PINS-1:0]       req_i,
    input  logic [N_PINS*LVL_W-1:0] lvl_i,
    input  logic [LVL_W-1:0]        mask_i,
    output logic                    irq_o,
    output logic [VEC_W-1:0]        vec_o,
    output logic [LVL_W-1:0]        win_lvl_o
);
    typedef struct packed {
        logic             irq;
        logic [VEC_W-1:0] vec;
        logic [LVL_W-1:0] lvl;
    } arb_t;

    arb_t             st_d, st_q;
    logic             found;
    logic [LVL_W-1:0] best_lvl;
    int unsigned      best_idx;

    always_comb begin
        found    = 1'b0;
        best_lvl = '0;
        best_idx = 0;
        // Ascending scan with strict compare: equal levels keep the lower index
        for (int unsigned i = 0; i < N_PINS; i++) begin
            if (req_i[i] && (!found || lvl_i[LVL_W*i +: LVL_W] > best_lvl)) begin
                found    = 1'b1;
                best_lvl = lvl_i[LVL_W*i +: LVL_W];
                best_idx = i;
            end
        end
        st_d.irq = found && (best_lvl > mask_i);
        st_d.vec = st_d.irq ? VEC_W'(VEC_BASE + best_idx) : '0;
        st_d.lvl = st_d.irq ? best_lvl : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o     = st_q.irq;
    assign vec_o     = st_q.vec;
    assign win_lvl_o = st_q.lvl;
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
    import extirq_pkg::*;
#(
    parameter int unsigned N_PINS   = 8,
    parameter int unsigned LVL_W    = 3,
    parameter int unsigned VEC_W    = 5,
    parameter int unsigned VEC_BASE = 16
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [N_PINS-1:0]       pin_i,
    input  logic                    wr_en_i,
    input  logic [1:0]              addr_i,
    input  logic [N_PINS*LVL_W-1:0] wdata_i,
    output logic [N_PINS*LVL_W-1:0] rdata_o,
    input  logic [LVL_W-1:0]        mask_i,
    output logic                    irq_o,
    output logic [VEC_W-1:0]        vec_o
);
    localparam int unsigned DATA_W  = N_PINS * LVL_W;
    localparam int unsigned SENSE_W = 2 * N_PINS;

    typedef struct packed {
        logic [N_PINS-1:0]  en;
        logic [SENSE_W-1:0] sense;
        logic [DATA_W-1:0]  lvl;
    } cfg_t;

    cfg_t              cfg_d, cfg_q;
    logic [N_PINS-1:0] cur_pin, prev_pin, flag_q, clr_vec, req_vec;
    logic [LVL_W-1:0]  win_lvl;

    extirq_sync #(.N_PINS(N_PINS)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pin_i (pin_i),
        .cur_o (cur_pin),
        .prev_o(prev_pin)
    );

    extirq_detect #(.N_PINS(N_PINS)) u_detect (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cur_i  (cur_pin),
        .prev_i (prev_pin),
        .sense_i(cfg_q.sense),
        .clr_i  (clr_vec),
        .flag_o (flag_q)
    );

    always_comb begin
        cfg_d   = cfg_q;
        clr_vec = '0;
        if (wr_en_i) begin
            unique case (reg_addr_e'(addr_i))
                REG_FLAG:   clr_vec     = wdata_i[N_PINS-1:0];
                REG_ENABLE: cfg_d.en    = wdata_i[N_PINS-1:0];
                REG_SENSE:  cfg_d.sense = wdata_i[SENSE_W-1:0];
                default:    cfg_d.lvl   = wdata_i;
            endcase
        end
        unique case (reg_addr_e'(addr_i))
            REG_FLAG:   rdata_o = DATA_W'(flag_q);
            REG_ENABLE: rdata_o = DATA_W'(cfg_q.en);
            REG_SENSE:  rdata_o = DATA_W'(cfg_q.sense);
            default:    rdata_o = cfg_q.lvl;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign req_vec = flag_q & cfg_q.en;

    extirq_arb #(
        .N_PINS  (N_PINS),
        .LVL_W   (LVL_W),
        .VEC_W   (VEC_W),
        .VEC_BASE(VEC_BASE)
    ) u_arb (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (req_vec),
        .lvl_i    (cfg_q.lvl),
        .mask_i   (mask_i),
        .irq_o    (irq_o),
        .vec_o    (vec_o),
        .win_lvl_o(win_lvl)
    );
endmodule

// File: rtl/extirq_chk.sv
module extirq_chk #(
    parameter int unsigned N_PINS   = 8,
    parameter int unsigned LVL_W    = 3,
    parameter int unsigned VEC_W    = 5,
    parameter int unsigned VEC_BASE = 16
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic [N_PINS-1:0]     flag_q,
    input logic [N_PINS-1:0]     clr_vec,
    input logic [N_PINS-1:0]     req_vec,
    input logic [N_PINS-1:0]     cur_pin,
    input logic [2*N_PINS-1:0]   sense_cfg,
    input logic [LVL_W-1:0]      mask_i,
    input logic [LVL_W-1:0]      win_lvl,
    input logic                  irq_o,
    input logic [VEC_W-1:0]      vec_o
);
    localparam logic [VEC_W-1:0] VEC_LO = VEC_W'(VEC_BASE);
    localparam logic [VEC_W-1:0] VEC_HI = VEC_W'(VEC_BASE + N_PINS - 1);

    for (genvar gi = 0; gi < N_PINS; gi++) begin : g_pin
        AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flag_q[gi] && !clr_vec[gi]) |=> flag_q[gi]); // R3
        AST_LEVEL_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sense_cfg[2*gi +: 2] == 2'b00 && !cur_pin[gi]) |=> flag_q[gi]); // R8
    end

    AST_IRQ_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|req_vec) |=> !irq_o); // R4
    AST_VEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (vec_o >= VEC_LO && vec_o <= VEC_HI)); // R5
    AST_ABOVE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (win_lvl > $past(mask_i))); // R7
    AST_IDLE_VEC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_o |-> (vec_o == '0)); // R5
endmodule

bind extirq_ctrl extirq_chk #(
    .N_PINS  (N_PINS),
    .LVL_W   (LVL_W),
    .VEC_W   (VEC_W),
    .VEC_BASE(VEC_BASE)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flag_q   (flag_q),
    .clr_vec  (clr_vec),
    .req_vec  (req_vec),
    .cur_pin  (cur_pin),
    .sense_cfg(cfg_q.sense),
    .mask_i   (mask_i),
    .win_lvl  (win_lvl),
    .irq_o    (irq_o),
    .vec_o    (vec_o)
);

// File: tb/tb_extirq_ctrl.sv
`timescale 1ns/1ps
module tb_extirq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin = 8'hFF;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [23:0] wdata = '0;
    logic [23:0] rdata;
    logic [2:0]  mask = 3'd0;
    logic        irq;
    logic [4:0]  vec;

    int checks = 0;
    int errors = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #10 clk = ~clk;

    extirq_ctrl dut (
        .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .mask_i(mask), .irq_o(irq), .vec_o(vec)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [23:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [23:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic model(input logic [7:0] req, input logic [23:0] lv, input logic [2:0] mk,
                         output logic exp_irq, output logic [4:0] exp_vec);
        int best = -1;
        int bl = 0;
        for (int i = 0; i < 8; i++)
            if (req[i] && (best < 0 || int'(lv[3*i +: 3]) > bl)) begin
                best = i;
                bl = int'(lv[3*i +: 3]);
            end
        exp_irq = (best >= 0) && (bl > int'(mk));
        exp_vec = exp_irq ? 5'(16 + best) : 5'd0;
    endtask

    task automatic step_lcg();
        lcg = lcg * 32'd1103515245 + 32'd12345;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] d;
        logic        ei;
        logic [4:0]  ev;
        cyc(3);
        rst_n = 1'b1;
        cyc(4);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check("R1 reg after reset", 32'(d), 32'h0);
        end
        check("R1 irq after reset", 32'(irq), 0);
        check("R1 vec after reset", 32'(vec), 0);

        // R2/R3/R8/R9 sense-mode sweep, every pin and every mode
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 8; p++) begin
                logic [7:0] bitp;
                logic [7:0] e;
                bitp = 8'(1 << p);
                wr(2'd2, 24'(m << (2*p)));
                rd(2'd2, d);
                check("R9 sense readback", 32'(d), 32'(m << (2*p)));
                wr(2'd0, 24'hFF);
                cyc(4);
                pin[p] = 1'b0;
                cyc(4);
                e = (m != 2) ? bitp : 8'h0;
                rd(2'd0, d);
                check("R2 flag after fall", 32'(d), 32'(e));
                wr(2'd0, 24'h0);
                cyc(1);
                rd(2'd0, d);
                check("R3 zero write keeps flag", 32'(d), 32'(e));
                wr(2'd0, 24'(bitp));
                cyc(3);
                e = (m == 0) ? bitp : 8'h0;
                rd(2'd0, d);
                check("R8 clear while low", 32'(d), 32'(e));
                pin[p] = 1'b1;
                cyc(4);
                if (m >= 2) e = bitp;
                rd(2'd0, d);
                check("R2 flag after rise", 32'(d), 32'(e));
                wr(2'd0, 24'(bitp));
                cyc(3);
                rd(2'd0, d);
                check("R3 clear with pin high", 32'(d), 0);
            end
        end
        wr(2'd2, 24'h0);

        // R7/R5 exhaustive mask-versus-level sweep, one pin at a time
        for (int p = 0; p < 8; p++) begin
            pin = ~8'(1 << p);
            cyc(4);
            wr(2'd0, 24'hFF);
            cyc(4);
            wr(2'd1, 24'(1 << p));
            for (int l = 0; l < 8; l++) begin
                wr(2'd3, 24'(l << (3*p)));
                for (int k = 0; k < 8; k++) begin
                    mask = 3'(k);
                    cyc(2);
                    check("R7 irq vs mask", 32'(irq), 32'(l > k));
                    check("R5 vector number", 32'(vec), (l > k) ? 32'(16 + p) : 0);
                end
            end
        end
        pin = 8'hFF;
        cyc(4);
        wr(2'd0, 24'hFF);

        // R6 ties: equal levels, lowest index wins
        pin = 8'h00;
        cyc(4);
        wr(2'd1, 24'hFF);
        wr(2'd3, {8{3'd5}});
        mask = 3'd0;
        cyc(2);
        check("R6 tie all pins", 32'(vec), 16);
        wr(2'd1, 24'hF0);
        cyc(2);
        check("R6 tie upper pins", 32'(vec), 20);
        wr(2'd1, 24'h00);
        cyc(2);
        check("R4 no enables no irq", 32'(irq), 0);

        // R4/R6 pseudo-random arbitration
        for (int t = 0; t < 200; t++) begin
            logic [7:0]  lo;
            logic [7:0]  en;
            logic [23:0] lv;
            logic [2:0]  mk;
            step_lcg(); lo = lcg[23:16];
            step_lcg(); en = lcg[23:16];
            step_lcg(); lv = lcg[31:8];
            step_lcg(); mk = lcg[18:16];
            pin = ~lo;
            cyc(4);
            wr(2'd0, 24'hFF);
            cyc(4);
            wr(2'd1, 24'(en));
            wr(2'd3, lv);
            mask = mk;
            cyc(3);
            rd(2'd0, d);
            check("R4 flags independent of enable", 32'(d), 32'(lo));
            model(lo & en, lv, mk, ei, ev);
            check("R6 arbitration irq", 32'(irq), 32'(ei));
            check("R6 arbitration vector", 32'(vec), 32'(ev));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule